// File: doc/BRIEF.md
# Flash Command Register Bank

This block is an APB register bank that sits in front of a quad-SPI serial engine. Software stages a single flash transaction in it: the command byte, the direction and address flags, the number of dummy clocks, the byte count, a 24-bit flash address, an optional continuous-read mode byte, and up to four 32-bit words of outgoing data. The decoded fields and the outgoing data go straight to the serial engine.

A transaction is launched by a 0-to-1 change of one bit in the instruction word. The block turns that change into a one-cycle start pulse and raises a busy flag. Software polls the busy flag in the status word. When the engine returns its done strobe, the block clears busy and captures the 128-bit receive value into four readable result words. A command with both direction flags clear and a byte count of zero is a bare opcode, such as write-enable or reset.

Top module: `flash_cmd_regs`

## Requirements
- R1: After a synchronous active-high reset, every register reads zero at every mapped offset, busy is 0, and all engine-side outputs, including the start pulse, are 0.
- R2: Word offsets are as follows. Control is at 0x00 and reads back only bits [24:16]. Status is at 0x04. Instruction is at 0x08 and reads back bits [23:0]. Address is at 0x0C and reads back bits [23:0]. Transmit words at 0x20, 0x24, 0x28 and 0x2C read back all 32 bits. Any offset not listed reads zero.
- R3: The instruction word is decoded onto the engine outputs as follows. Bits [7:0] are the opcode. Bit 9 is read, bit 10 is write and bit 11 is address-enable. Bits [15:12] are the dummy-clock count. Bits [23:16] are the byte count minus one.
- R4: In the control word, bits [23:16] drive the mode byte and bit 24 drives the mode-enable output.
- R5: The transmit word at offset 0x20+4k appears on bits [32k+31:32k] of the transmit data bus.
- R6: The start pulse is high for exactly one clock. It appears on the second rising edge after the APB write that changes instruction bit 8 from 0 to 1. A write that leaves bit 8 at 1, or clears it, produces no pulse.
- R7: Status bit 0 (busy) becomes 1 on the same edge as the start pulse. It stays 1 until the edge that samples the done strobe.
- R8: A 0-to-1 change of bit 8 that happens while busy is 1 is dropped. It produces no start pulse, either at that time or after the transaction ends.
- R9: A done strobe sampled while busy is 1 captures the receive bus. Bits [32k+31:32k] of that bus become readable at offset 0x10+4k.
- R10: A done strobe sampled while busy is 0 leaves the result words and busy unchanged.
- R11: APB writes to the status offset and to the result offsets 0x10 to 0x1C have no effect.
- R12: pready is always 1 and pslverr is always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write when 1 |
| paddr | input | ADDR_W | APB byte address |
| pwdata | input | DATA_W | APB write data |
| prdata | output | DATA_W | APB read data, registered in the setup phase |
| pready | output | 1 | Always 1 |
| pslverr | output | 1 | Always 0 |
| eng_opcode | output | 8 | Command byte |
| eng_rd | output | 1 | Transaction reads data |
| eng_wr | output | 1 | Transaction writes data |
| eng_addr_en | output | 1 | Send the address phase |
| eng_dummy | output | 4 | Dummy clock count |
| eng_len | output | 8 | Byte count minus one |
| eng_addr | output | 24 | Flash address |
| eng_mode_byte | output | 8 | Continuous-read mode byte |
| eng_mode_en | output | 1 | Send the mode byte after the address |
| eng_start | output | 1 | One-cycle launch pulse |
| eng_txdata | output | N_WORDS*DATA_W | Outgoing data, word 0 in the low bits |
| eng_done | input | 1 | Engine finished strobe |
| eng_rxdata | input | N_WORDS*DATA_W | Received data, first word in the low bits |

## Verification
The assertions assume the engine raises its done strobe only in reply to a start pulse and only while busy is high. They also assume the receive bus is valid in the cycle that done is sampled. The bench honours this by asserting done for one clock with the receive value already driven. The single exception is a deliberate stray done while idle, which exists to show that it is ignored. APB cycles are always a full setup phase followed by one access phase, so the registered read data and the write strobe see the protocol in the form the design expects.

// File: rtl/fcr_pkg.sv
package fcr_pkg;
  // Instruction word bit positions (decoded by software and engine)
  localparam int INSTR_W     = 24;
  localparam int START_BIT   = 8;
  // Control word fields
  localparam int MODE_LSB    = 16;
  localparam int MODE_EN_BIT = 24;
  localparam int CTRL_W      = MODE_EN_BIT - MODE_LSB + 1;
  // Word indices of the register map (byte offset / 4)
  localparam int IDX_CTRL    = 0;
  localparam int IDX_STAT    = 1;
  localparam int IDX_INSTR   = 2;
  localparam int IDX_ADDR    = 3;
  localparam int IDX_RX      = 4;

  typedef struct packed {
    logic [7:0] len_m1;
    logic [3:0] dummy;
    logic       addr_en;
    logic       wr;
    logic       rd;
    logic       start;
    logic [7:0] opcode;
  } instr_t;
endpackage

// File: rtl/fcr_apb_port.sv
module fcr_apb_port #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  localparam int IDX_W = ADDR_W - 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [DATA_W-1:0] rd_word,
  output logic [IDX_W-1:0]  idx,
  output logic              wr_hit,
  output logic [DATA_W-1:0] prdata
);
  logic unused_lsb;
  assign unused_lsb = ^paddr[1:0];
  assign idx    = paddr[ADDR_W-1:2];
  assign wr_hit = psel & penable & pwrite;

  // read data is captured in the setup phase so the access phase sees a register
  always_ff @(posedge clk) begin
    if (rst) prdata <= '0;
    else if (psel && !penable && !pwrite) prdata <= rd_word;
  end
endmodule

// File: rtl/fcr_word_bank.sv
module fcr_word_bank #(
  parameter int N = 4,
  parameter int W = 32
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [N-1:0]   wr_en,
  input  logic [W-1:0]   wr_word,
  input  logic           load,
  input  logic [N*W-1:0] load_data,
  output logic [N*W-1:0] words
);
  logic [W-1:0] q [N];

  for (genvar k = 0; k < N; k++) begin : g_word
    always_ff @(posedge clk) begin
      if (rst)           q[k] <= '0;
      else if (load)     q[k] <= load_data[k*W +: W];
      else if (wr_en[k]) q[k] <= wr_word;
    end
    assign words[k*W +: W] = q[k];
  end
endmodule

// File: rtl/fcr_launch.sv
module fcr_launch (
  input  logic clk,
  input  logic rst,
  input  logic start_bit,
  input  logic done,
  output logic start,
  output logic busy,
  output logic capture
);
  logic prev_q;
  logic launch;

  assign launch  = start_bit & ~prev_q & ~busy;
  assign capture = done & busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= 1'b0;
      start  <= 1'b0;
      busy   <= 1'b0;
    end else begin
      prev_q <= start_bit;
      start  <= launch;
      if (launch)    busy <= 1'b1;
      else if (done) busy <= 1'b0;
    end
  end
endmodule

// File: rtl/flash_cmd_regs.sv
module flash_cmd_regs
  import fcr_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 32,
  parameter int N_WORDS  = 4,
  parameter int FADDR_W  = 24,
  localparam int IDX_W   = ADDR_W - 2,
  localparam int BUS_W   = N_WORDS * DATA_W,
  localparam int IDX_TX  = IDX_RX + N_WORDS
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               psel,
  input  logic               penable,
  input  logic               pwrite,
  input  logic [ADDR_W-1:0]  paddr,
  input  logic [DATA_W-1:0]  pwdata,
  output logic [DATA_W-1:0]  prdata,
  output logic               pready,
  output logic               pslverr,
  output logic [7:0]         eng_opcode,
  output logic               eng_rd,
  output logic               eng_wr,
  output logic               eng_addr_en,
  output logic [3:0]         eng_dummy,
  output logic [7:0]         eng_len,
  output logic [FADDR_W-1:0] eng_addr,
  output logic [7:0]         eng_mode_byte,
  output logic               eng_mode_en,
  output logic               eng_start,
  output logic [BUS_W-1:0]   eng_txdata,
  input  logic               eng_done,
  input  logic [BUS_W-1:0]   eng_rxdata
);
  logic [IDX_W-1:0]   idx;
  logic               wr_hit;
  logic [DATA_W-1:0]  rd_word;
  logic [CTRL_W-1:0]  ctrl_q;
  instr_t             instr_q;
  logic [FADDR_W-1:0] addr_q;
  logic               busy_q;
  logic               capture;
  logic [N_WORDS-1:0] tx_wen;
  logic [BUS_W-1:0]   rx_flat;

  assign pready  = 1'b1;
  assign pslverr = 1'b0;

  fcr_apb_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_port (
    .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .rd_word(rd_word), .idx(idx), .wr_hit(wr_hit), .prdata(prdata)
  );

  // scalar registers
  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q  <= '0;
      instr_q <= '0;
      addr_q  <= '0;
    end else if (wr_hit) begin
      if (idx == IDX_W'(IDX_CTRL))  ctrl_q  <= pwdata[MODE_EN_BIT:MODE_LSB];
      if (idx == IDX_W'(IDX_INSTR)) instr_q <= pwdata[INSTR_W-1:0];
      if (idx == IDX_W'(IDX_ADDR))  addr_q  <= pwdata[FADDR_W-1:0];
    end
  end

  for (genvar k = 0; k < N_WORDS; k++) begin : g_txwen
    assign tx_wen[k] = wr_hit && (idx == IDX_W'(IDX_TX + k));
  end

  fcr_word_bank #(.N(N_WORDS), .W(DATA_W)) u_tx (
    .clk(clk), .rst(rst), .wr_en(tx_wen), .wr_word(pwdata),
    .load(1'b0), .load_data('0), .words(eng_txdata)
  );

  fcr_word_bank #(.N(N_WORDS), .W(DATA_W)) u_rx (
    .clk(clk), .rst(rst), .wr_en('0), .wr_word(pwdata),
    .load(capture), .load_data(eng_rxdata), .words(rx_flat)
  );

  fcr_launch u_launch (
    .clk(clk), .rst(rst), .start_bit(instr_q.start), .done(eng_done),
    .start(eng_start), .busy(busy_q), .capture(capture)
  );

  // read multiplexer
  always_comb begin
    rd_word = '0;
    if (idx == IDX_W'(IDX_CTRL))  rd_word[MODE_EN_BIT:MODE_LSB] = ctrl_q;
    if (idx == IDX_W'(IDX_STAT))  rd_word[0] = busy_q;
    if (idx == IDX_W'(IDX_INSTR)) rd_word[INSTR_W-1:0] = instr_q;
    if (idx == IDX_W'(IDX_ADDR))  rd_word[FADDR_W-1:0] = addr_q;
    for (int k = 0; k < N_WORDS; k++) begin
      if (idx == IDX_W'(IDX_RX + k)) rd_word = rx_flat[k*DATA_W +: DATA_W];
      if (idx == IDX_W'(IDX_TX + k)) rd_word = eng_txdata[k*DATA_W +: DATA_W];
    end
  end

  assign eng_opcode    = instr_q.opcode;
  assign eng_rd        = instr_q.rd;
  assign eng_wr        = instr_q.wr;
  assign eng_addr_en   = instr_q.addr_en;
  assign eng_dummy     = instr_q.dummy;
  assign eng_len       = instr_q.len_m1;
  assign eng_addr      = addr_q;
  assign eng_mode_byte = ctrl_q[7:0];
  assign eng_mode_en   = ctrl_q[CTRL_W-1];
endmodule

// File: rtl/flash_cmd_regs_chk.sv
module flash_cmd_regs_chk #(
  parameter int BUS_W = 128
) (
  input logic             clk,
  input logic             rst,
  input logic             eng_start,
  input logic             busy,
  input logic             eng_done,
  input logic [BUS_W-1:0] eng_rxdata,
  input logic [BUS_W-1:0] rx_flat
);
  // R6
  start_one_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    eng_start |=> !eng_start);
  // R7
  start_sets_busy_chk: assert property (@(posedge clk) disable iff (rst)
    eng_start |-> busy);
  // R7
  busy_holds_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && !eng_done) |=> busy);
  // R8
  no_launch_when_busy_chk: assert property (@(posedge clk) disable iff (rst)
    busy |=> !eng_start);
  // R9
  capture_on_done_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && eng_done) |=> (!busy && rx_flat == $past(eng_rxdata)));
  // R10
  idle_done_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && eng_done) |=> $stable(rx_flat));
endmodule

bind flash_cmd_regs flash_cmd_regs_chk #(.BUS_W(BUS_W)) u_chk (
  .clk(clk), .rst(rst), .eng_start(eng_start), .busy(busy_q),
  .eng_done(eng_done), .eng_rxdata(eng_rxdata), .rx_flat(rx_flat)
);

// File: tb/flash_cmd_regs_bench.sv
module flash_cmd_regs_bench;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;
  localparam int NW     = 4;
  localparam int BW     = NW * DATA_W;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic psel = 0, penable = 0, pwrite = 0;
  logic [ADDR_W-1:0] paddr = '0;
  logic [DATA_W-1:0] pwdata = '0;
  logic [DATA_W-1:0] prdata;
  logic pready, pslverr;
  logic [7:0] eng_opcode, eng_len, eng_mode_byte;
  logic eng_rd, eng_wr, eng_addr_en, eng_mode_en, eng_start;
  logic [3:0] eng_dummy;
  logic [23:0] eng_addr;
  logic [BW-1:0] eng_txdata;
  logic eng_done = 1'b0;
  logic [BW-1:0] eng_rxdata = '0;

  int checks = 0, failures = 0, pulses = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  flash_cmd_regs u_flash_cmd_regs (
    .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready), .pslverr(pslverr),
    .eng_opcode(eng_opcode), .eng_rd(eng_rd), .eng_wr(eng_wr), .eng_addr_en(eng_addr_en),
    .eng_dummy(eng_dummy), .eng_len(eng_len), .eng_addr(eng_addr),
    .eng_mode_byte(eng_mode_byte), .eng_mode_en(eng_mode_en), .eng_start(eng_start),
    .eng_txdata(eng_txdata), .eng_done(eng_done), .eng_rxdata(eng_rxdata)
  );

  always @(negedge clk) if (eng_start) pulses++;

  // {offset, write value, expected readback}
  localparam logic [71:0] VEC [10] = '{
    {8'h00, 32'hFFFF_FFFF, 32'h01FF_0000},
    {8'h04, 32'hFFFF_FFFF, 32'h0000_0000},
    {8'h08, 32'hFFFF_FEFF, 32'h00FF_FEFF},
    {8'h0C, 32'hAB12_3456, 32'h0012_3456},
    {8'h10, 32'hDEAD_BEEF, 32'h0000_0000},
    {8'h20, 32'h1111_2222, 32'h1111_2222},
    {8'h24, 32'h3333_4444, 32'h3333_4444},
    {8'h28, 32'h5555_6666, 32'h5555_6666},
    {8'h2C, 32'h7777_8888, 32'h7777_8888},
    {8'h3C, 32'hFFFF_FFFF, 32'h0000_0000}
  };

  task automatic check(input string req, input logic [BW-1:0] act, input logic [BW-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic apb_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    psel = 1; pwrite = 1; penable = 0; paddr = a; pwdata = d;
    @(negedge clk);
    penable = 1;
    @(negedge clk);
    psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic apb_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    psel = 1; pwrite = 0; penable = 0; paddr = a;
    @(negedge clk);
    penable = 1;
    @(negedge clk);
    d = prdata;
    psel = 0; penable = 0;
  endtask

  task automatic engine_done(input logic [BW-1:0] rx);
    @(negedge clk);
    eng_done = 1; eng_rxdata = rx;
    @(negedge clk);
    eng_done = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    int p0;
    repeat (3) @(negedge clk);
    rst = 0;

    // R1 reset state
    for (int a = 0; a < 12; a++) begin
      apb_read(8'(a * 4), rd);
      check("R1 reset readback", rd, 0);
    end
    check("R1 engine outputs", {eng_opcode, eng_len, eng_dummy, eng_rd, eng_wr, eng_addr_en,
          eng_addr, eng_mode_byte, eng_mode_en, eng_start}, 0);
    check("R1 txdata", eng_txdata, 0);
    check("R12 pready/pslverr", {pready, pslverr}, 2'b10);

    // R2 map readback, R11 ignored writes (table walk)
    for (int i = 0; i < 10; i++) begin
      apb_write(VEC[i][71:64], VEC[i][63:32]);
      apb_read(VEC[i][71:64], rd);
      check("R2 R11 table", rd, VEC[i][31:0]);
    end
    check("R5 txdata word order", eng_txdata,
          {32'h7777_8888, 32'h5555_6666, 32'h3333_4444, 32'h1111_2222});
    check("R6 no pulse from table", pulses, 0);

    // R4 control fields
    apb_write(8'h00, 32'h01A0_0000);
    check("R4 mode on", {eng_mode_en, eng_mode_byte}, {1'b1, 8'hA0});
    apb_write(8'h00, 32'h00A5_0000);
    check("R4 mode off", {eng_mode_en, eng_mode_byte}, {1'b0, 8'hA5});

    // R3 instruction decode
    apb_write(8'h0C, 32'h0000_1234);
    apb_write(8'h08, 32'h000F_6A0B);
    check("R3 fields", {eng_opcode, eng_rd, eng_wr, eng_addr_en, eng_dummy, eng_len},
          {8'h0B, 1'b1, 1'b0, 1'b1, 4'd6, 8'h0F});
    check("R3 address", eng_addr, 24'h1234);
    apb_write(8'h08, 32'h0000_0406);
    check("R3 write flag", {eng_opcode, eng_rd, eng_wr, eng_addr_en, eng_len},
          {8'h06, 1'b0, 1'b1, 1'b0, 8'h00});
    apb_write(8'h08, 32'h000F_6A0B);

    // R6 launch on 0->1 of bit 8
    p0 = pulses;
    apb_write(8'h08, 32'h000F_6B0B);
    check("R6 no pulse before second edge", eng_start, 0);
    @(negedge clk);
    check("R6 pulse high", eng_start, 1);
    @(negedge clk);
    check("R6 pulse one cycle", eng_start, 0);
    check("R6 pulse count", pulses - p0, 1);
    apb_read(8'h04, rd);
    check("R7 busy set", rd, 1);

    // R8 edge while busy is dropped
    apb_write(8'h08, 32'h000F_6A0B);
    apb_write(8'h08, 32'h000F_6B0B);
    check("R8 no pulse while busy", pulses - p0, 1);
    apb_read(8'h04, rd);
    check("R7 busy held", rd, 1);

    // R9 capture on done
    engine_done({32'hD4D4_0004, 32'hC3C3_0003, 32'hB2B2_0002, 32'hA1A1_0001});
    apb_read(8'h04, rd);
    check("R7 busy cleared", rd, 0);
    for (int k = 0; k < NW; k++) begin
      apb_read(8'(8'h10 + 4 * k), rd);
      check("R9 result word", rd, {k[7:0] * 8'h11 + 8'hA1, k[7:0] * 8'h11 + 8'hA1, 16'(k + 1)});
    end
    repeat (4) @(negedge clk);
    check("R8 not deferred", pulses - p0, 1);
    check("R12 pready/pslverr", {pready, pslverr}, 2'b10);

    // R10 stray done while idle
    engine_done({4{32'hBAD0_BAD0}});
    apb_read(8'h10, rd);
    check("R10 result kept", rd, 32'hA1A1_0001);
    apb_read(8'h04, rd);
    check("R10 busy stays 0", rd, 0);

    // R11 writes to result and status ignored
    apb_write(8'h14, 32'h0BAD_F00D);
    apb_read(8'h14, rd);
    check("R11 result write ignored", rd, 32'hB2B2_0002);
    apb_write(8'h04, 32'h0000_0001);
    apb_read(8'h04, rd);
    check("R11 status write ignored", rd, 0);

    // R6 rewrite with bit 8 already set, then clear: no pulse; then set: pulse
    p0 = pulses;
    apb_write(8'h08, 32'h0000_0166);
    repeat (3) @(negedge clk);
    check("R6 bit stays 1 no pulse", pulses - p0, 0);
    apb_write(8'h08, 32'h0000_0066);
    repeat (3) @(negedge clk);
    check("R6 clear no pulse", pulses - p0, 0);
    apb_write(8'h08, 32'h0000_0166);
    repeat (3) @(negedge clk);
    check("R6 bare opcode launch", pulses - p0, 1);
    check("R3 bare opcode", {eng_opcode, eng_rd, eng_wr, eng_len}, {8'h66, 1'b0, 1'b0, 8'h00});
    engine_done('0);
    apb_read(8'h04, rd);
    check("R7 busy cleared again", rd, 0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule